// File: doc/BRIEF.md
# Receive Word Packer with Transmit and Receive FIFOs

This block sits between a serial shift engine and a register bus. Bytes that the engine has received arrive one at a time through a strobe. The packer gathers them into 32-bit entries whatever word length the link uses, and it writes each entry into a receive FIFO. When a transfer stops part way through a word, the packer closes the entry early. A three-bit count travels with the entry so that the reader knows how many of its bytes are meaningful. A matching transmit FIFO holds 32-bit words that the bus writes and the engine drains.

Each FIFO has a control word that holds an enable, a flush strobe and a trigger level. Each FIFO also raises a service request based on its fill level. Push into a full FIFO and pop from an empty FIFO each raise a one-cycle error strobe. A byte countdown can be loaded so that an entry closes on the last expected byte without a separate end-of-transfer pulse. Packed status words report both fill levels, the byte count of the receive head, and the depths that were built.

Top module: `rx_word_packer`

## Requirements
- R1: After reset both fill levels are 0, both requests and all four error strobes are low, and both control readbacks are 0. Both FIFOs come out of reset disabled with trigger 0.
- R2: Four received bytes form one entry. The first byte lands in bits 31:24 and the last in bits 7:0. The count at `rx_status[30:28]` reads 4 for that entry.
- R3: A pulse on `xfer_end` closes a partial entry of n bytes (n = 1..3). The pulse may come with the last byte or after it. The first byte of the entry lands in bits 8(n-1)+7 : 8(n-1), the last byte in 7:0, and all higher bits are zero. The head count reads n.
- R4: Loading the byte countdown with N makes the Nth byte that follows close its entry, even when that entry is partial.
- R5: `fifo_status[5:0]` holds the receive fill level and `fifo_status[13:8]` the transmit fill level. Each push raises its level by one and each pop lowers it by one.
- R6: A control write sets the enable from bit 0 and the trigger from bits 13:8. When bit 1 is set, the write also empties the FIFO and, for receive, discards the partial bytes. The readback shows enable and trigger, and bit 1 always reads 0.
- R7: `rx_req` is high when receive is enabled, its level is nonzero, and either the level is at or above the trigger or an entry closed early is waiting.
- R8: `tx_req` is high when transmit is enabled and its level is at or below the trigger.
- R9: A push into a full FIFO raises its overflow strobe for one cycle. The push is dropped, and the level and head stay as they were.
- R10: A pop from an empty enabled FIFO raises its underflow strobe for one cycle, and the level stays 0.
- R11: `id_word[29:24]` holds the transmit depth and `id_word[21:16]` the receive depth.
- R12: A disabled FIFO ignores pushes, so its level does not change, and it keeps its request low.
- R13: Entries leave each FIFO in the order they entered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_ctrl_we | input | 1 | Receive control write strobe |
| rx_ctrl_wdata | input | 32 | Receive control value: enable bit 0, flush bit 1, trigger 13:8 |
| tx_ctrl_we | input | 1 | Transmit control write strobe |
| tx_ctrl_wdata | input | 32 | Transmit control value, same layout |
| rx_ctrl_q | output | 32 | Receive control readback |
| tx_ctrl_q | output | 32 | Transmit control readback |
| in_byte_vld | input | 1 | Received byte strobe from the shift engine |
| in_byte | input | 8 | Received byte |
| xfer_end | input | 1 | End of transfer, closes a partial entry |
| todo_load | input | 1 | Load the byte countdown |
| todo_val | input | TODO_W | Countdown value in bytes |
| rx_pop | input | 1 | Reader removes the receive head |
| rx_data | output | 32 | Receive head data, zero when empty |
| rx_status | output | 32 | Head byte count at bits 30:28, zero when empty |
| tx_push | input | 1 | Bus writes a transmit word |
| tx_wdata | input | 32 | Transmit word |
| tx_pop | input | 1 | Engine takes the transmit head |
| tx_data | output | 32 | Transmit head word |
| fifo_status | output | 32 | Receive level 5:0, transmit level 13:8 |
| id_word | output | 32 | Built depths: transmit 29:24, receive 21:16 |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| rx_ovf | output | 1 | Receive overflow strobe |
| rx_unf | output | 1 | Receive underflow strobe |
| tx_ovf | output | 1 | Transmit overflow strobe |
| tx_unf | output | 1 | Transmit underflow strobe |

## Verification
Several properties are checked on every cycle. Each level stays within its depth and moves by at most one per cycle unless a flush clears it. An overflow strobe appears only one cycle after the level sat at the full depth, and an underflow strobe only one cycle after the level was zero. A request never follows a cycle in which its FIFO was disabled, and the head byte count never exceeds four. Some behaviour shows only through the bench's scenarios: where the bytes land inside full and partial entries, entries closed by the countdown, the order in which entries leave, request thresholds, flush, and dropped data on overflow.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  localparam int LVL_W  = 6;
  localparam int WORD_W = 32;
  localparam int NB_W   = 3;

  typedef struct packed {
    logic [NB_W-1:0]   nbytes;
    logic [WORD_W-1:0] data;
  } rx_entry_t;

  localparam int RX_ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/wpk_fifo.sv
module wpk_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level,
  output logic             ovf,
  output logic             unf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full    = (level == FULL_LVL);
  assign empty   = (level == '0);
  assign do_pop  = en && pop && !empty && !flush;
  assign do_push = en && push && !flush && (!full || do_pop);
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= en && push && !flush && full && !do_pop;
      unf <= en && pop && !flush && empty;
    end
  end
endmodule

// File: rtl/wpk_packer.sv
module wpk_packer #(
  parameter int TODO_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              xfer_end,
  input  logic              todo_load,
  input  logic [TODO_W-1:0] todo_val,
  output logic              out_push,
  output logic [31:0]       out_data,
  output logic [2:0]        out_nb,
  output logic              out_partial
);
  logic [23:0]       acc;
  logic [1:0]        cnt;
  logic [TODO_W-1:0] todo;
  logic              todo_last, close;

  assign todo_last = (todo == TODO_W'(1));
  assign out_nb    = 3'(cnt) + 3'(byte_vld);
  assign out_data  = byte_vld ? {acc, byte_in} : {8'h00, acc};
  assign close     = (byte_vld && (out_nb == 3'd4 || todo_last)) ||
                     (xfer_end && out_nb != 3'd0);
  assign out_push    = close && !clear;
  assign out_partial = out_push && (out_nb != 3'd4);

  always_ff @(posedge clk) begin
    if (rst || clear || close) begin
      acc <= '0;
      cnt <= '0;
    end else if (byte_vld) begin
      acc <= {acc[15:0], byte_in};
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            todo <= '0;
    else if (todo_load)                 todo <= todo_val;
    else if (byte_vld && todo != '0)    todo <= todo - 1'b1;
  end
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer #(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  parameter int TODO_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_ctrl_we,
  input  logic [31:0]       rx_ctrl_wdata,
  input  logic              tx_ctrl_we,
  input  logic [31:0]       tx_ctrl_wdata,
  output logic [31:0]       rx_ctrl_q,
  output logic [31:0]       tx_ctrl_q,
  input  logic              in_byte_vld,
  input  logic [7:0]        in_byte,
  input  logic              xfer_end,
  input  logic              todo_load,
  input  logic [TODO_W-1:0] todo_val,
  input  logic              rx_pop,
  output logic [31:0]       rx_data,
  output logic [31:0]       rx_status,
  input  logic              tx_push,
  input  logic [31:0]       tx_wdata,
  input  logic              tx_pop,
  output logic [31:0]       tx_data,
  output logic [31:0]       fifo_status,
  output logic [31:0]       id_word,
  output logic              rx_req,
  output logic              tx_req,
  output logic              rx_ovf,
  output logic              rx_unf,
  output logic              tx_ovf,
  output logic              tx_unf
);
  import wpk_pkg::*;

  localparam logic [LVL_W-1:0] RX_DEPTH_F = LVL_W'(RX_DEPTH);
  localparam logic [LVL_W-1:0] TX_DEPTH_F = LVL_W'(TX_DEPTH);

  logic             rx_en_q, tx_en_q, rx_flush, tx_flush, part_pend;
  logic [LVL_W-1:0] rx_trig_q, tx_trig_q, rx_lvl, tx_lvl;
  logic             pk_push, pk_partial;
  logic [31:0]      pk_data;
  logic [2:0]       pk_nb;
  rx_entry_t        pk_entry, rx_head;
  logic             unused_ctrl_bits;

  assign unused_ctrl_bits = ^{rx_ctrl_wdata[31:14], rx_ctrl_wdata[7:2],
                              tx_ctrl_wdata[31:14], tx_ctrl_wdata[7:2]};

  assign rx_flush = rx_ctrl_we && rx_ctrl_wdata[1];
  assign tx_flush = tx_ctrl_we && tx_ctrl_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en_q   <= 1'b0;
      tx_en_q   <= 1'b0;
      rx_trig_q <= '0;
      tx_trig_q <= '0;
    end else begin
      if (rx_ctrl_we) begin
        rx_en_q   <= rx_ctrl_wdata[0];
        rx_trig_q <= rx_ctrl_wdata[13:8];
      end
      if (tx_ctrl_we) begin
        tx_en_q   <= tx_ctrl_wdata[0];
        tx_trig_q <= tx_ctrl_wdata[13:8];
      end
    end
  end

  assign rx_ctrl_q = {18'b0, rx_trig_q, 7'b0, rx_en_q};
  assign tx_ctrl_q = {18'b0, tx_trig_q, 7'b0, tx_en_q};

  wpk_packer #(.TODO_W(TODO_W)) packer_i (
    .clk(clk), .rst(rst), .clear(rx_flush),
    .byte_vld(in_byte_vld), .byte_in(in_byte), .xfer_end(xfer_end),
    .todo_load(todo_load), .todo_val(todo_val),
    .out_push(pk_push), .out_data(pk_data), .out_nb(pk_nb),
    .out_partial(pk_partial)
  );

  assign pk_entry = '{nbytes: pk_nb, data: pk_data};

  wpk_fifo #(.W(RX_ENTRY_W), .DEPTH(RX_DEPTH), .LVL_W(LVL_W)) rx_fifo_i (
    .clk(clk), .rst(rst), .en(rx_en_q), .flush(rx_flush),
    .push(pk_push), .wdata(pk_entry), .pop(rx_pop),
    .head(rx_head), .level(rx_lvl), .ovf(rx_ovf), .unf(rx_unf)
  );

  wpk_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH), .LVL_W(LVL_W)) tx_fifo_i (
    .clk(clk), .rst(rst), .en(tx_en_q), .flush(tx_flush),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .head(tx_data), .level(tx_lvl), .ovf(tx_ovf), .unf(tx_unf)
  );

  always_ff @(posedge clk) begin
    if (rst || rx_flush)                 part_pend <= 1'b0;
    else if (pk_partial && rx_en_q)      part_pend <= 1'b1;
    else if (rx_lvl == '0)               part_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_req <= 1'b0;
      tx_req <= 1'b0;
    end else begin
      rx_req <= rx_en_q && (rx_lvl != '0) && ((rx_lvl >= rx_trig_q) || part_pend);
      tx_req <= tx_en_q && (tx_lvl <= tx_trig_q);
    end
  end

  assign rx_data     = (rx_lvl == '0) ? '0 : rx_head.data;
  assign rx_status   = {1'b0, (rx_lvl == '0) ? 3'd0 : rx_head.nbytes, 28'b0};
  assign fifo_status = {18'b0, tx_lvl, 2'b0, rx_lvl};
  assign id_word     = {2'b0, TX_DEPTH_F, 2'b0, RX_DEPTH_F, 16'b0};
endmodule

// File: rtl/wpk_checker.sv
module wpk_checker #(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8
) (
  input logic       clk,
  input logic       rst,
  input logic [5:0] rx_lvl,
  input logic [5:0] tx_lvl,
  input logic [2:0] head_nb,
  input logic       rx_en,
  input logic       tx_en,
  input logic       rx_req,
  input logic       tx_req,
  input logic       rx_ovf,
  input logic       rx_unf,
  input logic       tx_ovf,
  input logic       tx_unf
);
  a_r5_rx_level_max: assert property (@(posedge clk) disable iff (rst)
    rx_lvl <= 6'(RX_DEPTH));
  a_r5_tx_level_max: assert property (@(posedge clk) disable iff (rst)
    tx_lvl <= 6'(TX_DEPTH));
  a_r5_rx_level_step: assert property (@(posedge clk) disable iff (rst)
    (rx_lvl == $past(rx_lvl)) || (rx_lvl == $past(rx_lvl) + 6'd1) ||
    (rx_lvl == $past(rx_lvl) - 6'd1) || (rx_lvl == 6'd0));
  a_r9_rx_ovf_full: assert property (@(posedge clk) disable iff (rst)
    rx_ovf |-> $past(rx_lvl) == 6'(RX_DEPTH));
  a_r9_tx_ovf_full: assert property (@(posedge clk) disable iff (rst)
    tx_ovf |-> $past(tx_lvl) == 6'(TX_DEPTH));
  a_r10_rx_unf_empty: assert property (@(posedge clk) disable iff (rst)
    rx_unf |-> $past(rx_lvl) == 6'd0);
  a_r10_tx_unf_empty: assert property (@(posedge clk) disable iff (rst)
    tx_unf |-> $past(tx_lvl) == 6'd0);
  a_r2_nbytes_range: assert property (@(posedge clk) disable iff (rst)
    head_nb <= 3'd4);
  a_r12_rx_req_off: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_en) |-> !rx_req);
  a_r12_tx_req_off: assert property (@(posedge clk) disable iff (rst)
    !$past(tx_en) |-> !tx_req);
endmodule

bind rx_word_packer wpk_checker #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) chk_i (
  .clk(clk), .rst(rst),
  .rx_lvl(fifo_status[5:0]), .tx_lvl(fifo_status[13:8]),
  .head_nb(rx_status[30:28]),
  .rx_en(rx_ctrl_q[0]), .tx_en(tx_ctrl_q[0]),
  .rx_req(rx_req), .tx_req(tx_req),
  .rx_ovf(rx_ovf), .rx_unf(rx_unf), .tx_ovf(tx_ovf), .tx_unf(tx_unf)
);

// File: tb/rx_word_packer_tb_top.sv
module rx_word_packer_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic rx_ctrl_we = 0, tx_ctrl_we = 0;
  logic [31:0] rx_ctrl_wdata = 0, tx_ctrl_wdata = 0, rx_ctrl_q, tx_ctrl_q;
  logic in_byte_vld = 0, xfer_end = 0, todo_load = 0;
  logic [7:0] in_byte = 0;
  logic [15:0] todo_val = 0;
  logic rx_pop, mon_pop = 0, test_pop = 0;
  logic [31:0] rx_data, rx_status, tx_data, fifo_status, id_word;
  logic tx_push = 0, tx_pop = 0;
  logic [31:0] tx_wdata = 0;
  logic rx_req, tx_req, rx_ovf, rx_unf, tx_ovf, tx_unf;

  int checks = 0, errors = 0;
  bit mon_on = 0, finished = 0;
  logic [34:0] exp_q[$];

  assign rx_pop = mon_pop | test_pop;
  always #5 clk = ~clk;

  rx_word_packer dut_i (
    .clk(clk), .rst(rst),
    .rx_ctrl_we(rx_ctrl_we), .rx_ctrl_wdata(rx_ctrl_wdata),
    .tx_ctrl_we(tx_ctrl_we), .tx_ctrl_wdata(tx_ctrl_wdata),
    .rx_ctrl_q(rx_ctrl_q), .tx_ctrl_q(tx_ctrl_q),
    .in_byte_vld(in_byte_vld), .in_byte(in_byte), .xfer_end(xfer_end),
    .todo_load(todo_load), .todo_val(todo_val),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_status(rx_status),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_data(tx_data),
    .fifo_status(fifo_status), .id_word(id_word),
    .rx_req(rx_req), .tx_req(tx_req),
    .rx_ovf(rx_ovf), .rx_unf(rx_unf), .tx_ovf(tx_ovf), .tx_unf(tx_unf)
  );

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit last);
    in_byte_vld = 1; in_byte = b; xfer_end = last;
    @(negedge clk);
    in_byte_vld = 0; xfer_end = 0;
  endtask

  task automatic send_word(input logic [31:0] w, input bit expect_it);
    if (expect_it) exp_q.push_back({3'd4, w});
    for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8], 1'b0);
  endtask

  task automatic wr_rx(input logic [31:0] v);
    rx_ctrl_we = 1; rx_ctrl_wdata = v; @(negedge clk); rx_ctrl_we = 0;
  endtask

  task automatic wr_tx(input logic [31:0] v);
    tx_ctrl_we = 1; tx_ctrl_wdata = v; @(negedge clk); tx_ctrl_we = 0;
  endtask

  task automatic push_tx(input logic [31:0] v);
    tx_push = 1; tx_wdata = v; @(negedge clk); tx_push = 0;
  endtask

  task automatic pop_tx();
    tx_pop = 1; @(negedge clk); tx_pop = 0;
  endtask

  task automatic pop_rx();
    test_pop = 1; @(negedge clk); test_pop = 0;
  endtask

  // Scoreboard monitor: compares the receive head with the expected queue (R13)
  always @(negedge clk) begin
    if (mon_on && fifo_status[5:0] != 6'd0) begin
      if (exp_q.size() == 0) begin
        check("R13 unexpected entry", {rx_status[30:28], rx_data}, 35'h0);
      end else begin
        check("R13 scoreboard entry", {rx_status[30:28], rx_data}, exp_q.pop_front());
      end
      mon_pop = 1;
    end else begin
      mon_pop = 0;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 levels", fifo_status, 0);
    check("R1 requests", {rx_req, tx_req}, 0);
    check("R1 strobes", {rx_ovf, rx_unf, tx_ovf, tx_unf}, 0);
    check("R1 ctrl readback", {rx_ctrl_q, tx_ctrl_q[2:0]}, 0);
    check("R11 depths", id_word, 32'h0808_0000);

    wr_rx(32'h0000_0201);
    wr_tx(32'h0000_0101);
    repeat (2) @(negedge clk);
    check("R8 tx_req empty below trigger", tx_req, 1);

    // R2 full words, R7 threshold
    send_word(32'hA1A2A3A4, 1);
    repeat (2) @(negedge clk);
    check("R5 rx level one", fifo_status[5:0], 1);
    check("R2 head data", rx_data, 32'hA1A2A3A4);
    check("R2 head count", rx_status[30:28], 4);
    check("R7 below trigger", rx_req, 0);
    send_word(32'hB1B2B3B4, 1);
    repeat (2) @(negedge clk);
    check("R7 at trigger", rx_req, 1);
    mon_on = 1;
    repeat (4) @(negedge clk);
    check("R13 queue drained", exp_q.size(), 0);
    check("R5 rx level after pops", fifo_status[5:0], 0);

    // R4 countdown closes a partial entry
    todo_load = 1; todo_val = 16'd6; @(negedge clk); todo_load = 0;
    exp_q.push_back({3'd4, 32'hC1C2C3C4});
    exp_q.push_back({3'd2, 32'h0000C5C6});
    for (int i = 1; i <= 6; i++) send_byte(8'hC0 + 8'(i), 1'b0);
    repeat (4) @(negedge clk);
    check("R4 countdown entries", exp_q.size(), 0);
    check("R4 level", fifo_status[5:0], 0);
    mon_on = 0;
    @(negedge clk);

    // R3 partial entry closed with last byte
    send_byte(8'hD1, 0); send_byte(8'hD2, 0); send_byte(8'hD3, 1);
    repeat (2) @(negedge clk);
    check("R3 partial data", rx_data, 32'h00D1D2D3);
    check("R3 partial count", rx_status[30:28], 3);
    check("R7 partial pending", rx_req, 1);
    pop_rx();
    // R3 end pulse after a lone byte
    send_byte(8'hE1, 0);
    xfer_end = 1; @(negedge clk); xfer_end = 0;
    check("R3 single byte data", rx_data, 32'h000000E1);
    check("R3 single byte count", rx_status[30:28], 1);
    pop_rx();
    check("R5 empty after pop", fifo_status[5:0], 0);

    // R9 overflow
    for (int k = 0; k < 8; k++) send_word(32'h01010101 * k + 32'h00010203, 0);
    check("R9 full level", fifo_status[5:0], 8);
    send_byte(8'h55, 0); send_byte(8'h66, 0); send_byte(8'h77, 0);
    send_byte(8'h88, 0);
    check("R9 overflow strobe", rx_ovf, 1);
    @(negedge clk);
    check("R9 strobe one cycle", rx_ovf, 0);
    check("R9 level held", fifo_status[5:0], 8);
    check("R9 head kept", rx_data, 32'h00010203);

    // R6 flush
    wr_rx(32'h0000_0203);
    check("R6 flush empties", fifo_status[5:0], 0);
    check("R6 readback", rx_ctrl_q, 32'h0000_0201);

    // R10 underflow
    test_pop = 1; @(negedge clk); test_pop = 0;
    check("R10 rx underflow", rx_unf, 1);
    check("R10 rx level", fifo_status[5:0], 0);

    // TX side
    push_tx(32'h7000_0000); push_tx(32'h7000_0001); push_tx(32'h7000_0002);
    check("R5 tx level", fifo_status[13:8], 3);
    @(negedge clk);
    check("R8 tx above trigger", tx_req, 0);
    check("R13 tx order 0", tx_data, 32'h7000_0000);
    pop_tx();
    check("R13 tx order 1", tx_data, 32'h7000_0001);
    pop_tx();
    repeat (2) @(negedge clk);
    check("R8 tx at trigger", tx_req, 1);
    check("R13 tx order 2", tx_data, 32'h7000_0002);
    pop_tx();
    pop_tx();
    check("R10 tx underflow", tx_unf, 1);
    for (int k = 0; k < 8; k++) push_tx(32'h9000_0000 + k);
    check("R9 tx no early overflow", tx_ovf, 0);
    push_tx(32'hDEAD_BEEF);
    check("R9 tx overflow", tx_ovf, 1);
    check("R9 tx level held", fifo_status[13:8], 8);

    // R12 disabled FIFOs ignore pushes
    wr_rx(32'h0000_0202);
    send_word(32'hF1F2F3F4, 0);
    repeat (2) @(negedge clk);
    check("R12 rx level unchanged", fifo_status[5:0], 0);
    check("R12 rx_req low", rx_req, 0);
    wr_tx(32'h0000_3F00);
    push_tx(32'h1234_5678);
    repeat (2) @(negedge clk);
    check("R12 tx level unchanged", fifo_status[13:8], 8);
    check("R12 tx_req low", tx_req, 0);

    finish_run();
  end
endmodule